// File: doc/BRIEF.md
# Serial bitstream configuration master

This block loads a configuration image into a programmable logic device through a one-bit serial configuration port. It takes bytes from an internal valid/ready source and drives the device's program request, configuration clock and serial data line. It reads back the device's init and done indications.

A load starts with a one-cycle start pulse together with a byte count and a clock half-period. The block first runs the program/init handshake. It then shifts every byte out most significant bit first on a generated clock. The device samples each bit on the rising edge of that clock.

Before each byte it checks whether the device has flagged a checksum failure. After the last byte it holds the data line high and keeps clocking until the device reports done. Each wait has its own timeout. The load ends either with `done_ok_o`, or with `error_o` and a two-bit code that names the failing step.

Top module: `cfg_serial_master`

## Requirements
- R1: A start pulse while idle asserts prog_o and busy_o from the next cycle and clears done_ok_o and error_o. A start pulse while busy_o is high has no effect: prog_o is not raised again and the load in progress completes.
- R2: prog_o stays asserted until init_i is seen high. If init_i does not rise within TMO_CYCLES cycles, the load fails with error code 0.
- R3: Once init_i is high, prog_o drops and the block waits for init_i to go low. If it stays high for TMO_CYCLES cycles, the load fails with error code 1.
- R4: Each accepted byte is sent as exactly eight rising edges of cclk_o, most significant bit first. sdata_o is stable while cclk_o is high.
- R5: Every high phase of cclk_o lasts exactly half_per_i cycles, with 0 treated as 1. The value is captured at start.
- R6: A byte is taken only when data_valid_i and data_ready_o are both high. If init_i is high while done_i is low when the next byte is due, no byte is taken and no further clock edge is made. The load fails with error code 2.
- R7: After the last byte, sdata_o is held at 1 and cclk_o keeps pulsing until done_i is seen high at the end of a low phase. The block then raises done_ok_o and drops busy_o.
- R8: If done_i does not rise within TMO_CYCLES cycles of the start of the done phase, the load fails with error code 3.
- R9: A byte count of zero takes no bytes and goes straight from the handshake to the done phase.
- R10: On any failure, error_o and err_code_o are set. busy_o, prog_o and cclk_o go low, and the block waits for the next start pulse.
- R11: After reset, busy_o, prog_o, cclk_o, sdata_o, data_ready_o, done_ok_o and error_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a load |
| byte_cnt_i | input | CNT_W | Number of image bytes, captured at start |
| half_per_i | input | HALF_W | Configuration clock half-period in cycles, captured at start |
| data_i | input | 8 | Image byte from the source |
| data_valid_i | input | 1 | Source holds a byte |
| data_ready_o | output | 1 | Block takes the byte this cycle if valid |
| prog_o | output | 1 | Program request to the device, 1 = asserted |
| cclk_o | output | 1 | Configuration clock, the device samples on its rising edge |
| sdata_o | output | 1 | Serial configuration data |
| init_i | input | 1 | Device init indication, 1 = asserted |
| done_i | input | 1 | Device done indication, 1 = done |
| busy_o | output | 1 | A load is in progress |
| done_ok_o | output | 1 | Last load completed, held until the next start |
| error_o | output | 1 | Last load failed, held until the next start |
| err_code_o | output | 2 | Failure: 0 init-start timeout, 1 init-clear timeout, 2 checksum error, 3 done timeout |

## Verification
The bench reconstructs bytes from the rising edges of cclk_o. A design that shifts the wrong way, drops or repeats a bit, or changes sdata_o while the clock is high gives a byte mismatch or a stability failure. High-phase lengths are measured at several half-periods, including 0. This exposes a divider that is off by one or treats 0 as a huge count.

Each failure path is driven separately: init never rising, init never clearing, a checksum error raised after the first byte, and done never arriving. A design that checks init at the wrong moment takes a second byte or clocks on. A design that fails to release program keeps prog_o high. The zero-byte load, a done that arrives exactly with the last data edge, and a start pulse in the middle of a load are also covered. These catch designs that request data they should not, emit an extra done-phase pulse, or restart the handshake.

// File: rtl/cfg_ser_pkg.sv
`timescale 1ns/1ps
package cfg_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG_ON,
    ST_PROG_OFF,
    ST_FETCH,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_FIN_LO,
    ST_FIN_HI
  } cfg_state_e;

  typedef enum logic [1:0] {
    ERR_INIT_START = 2'd0,
    ERR_INIT_CLEAR = 2'd1,
    ERR_CRC        = 2'd2,
    ERR_DONE_TMO   = 2'd3
  } cfg_err_e;

  // wait phase sharing one timeout window; 0 = untimed
  function automatic logic [1:0] wait_grp(cfg_state_e s);
    case (s)
      ST_PROG_ON:           return 2'd1;
      ST_PROG_OFF:          return 2'd2;
      ST_FIN_LO, ST_FIN_HI: return 2'd3;
      default:              return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_half_timer.sv
`timescale 1ns/1ps
module cfg_half_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] half_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q, lim_m1;

  assign lim_m1 = (half_i == '0) ? '0 : half_i - W'(1);
  assign last_o = (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || last_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + W'(1);
  end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> cnt_q <= lim_m1);

endmodule

// File: rtl/cfg_timeout.sv
`timescale 1ns/1ps
module cfg_timeout #(
  parameter int LIMIT = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (run_i && !expired_o)  cnt_q <= cnt_q + W'(1);
  end

  assert_clr_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !expired_o);

endmodule

// File: rtl/cfg_byte_shifter.sv
`timescale 1ns/1ps
module cfg_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_bit_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;

  assign msb_o      = sh_q[DATA_W-1];
  assign last_bit_o = (bit_q == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      bit_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b1};
      bit_q <= bit_q + BIT_W'(1);
    end
  end

  assert_load_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> msb_o == $past(data_i[DATA_W-1]));

endmodule

// File: rtl/cfg_serial_master.sv
`timescale 1ns/1ps
module cfg_serial_master
  import cfg_ser_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int HALF_W     = 8,
  parameter int TMO_CYCLES = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              prog_o,
  output logic              cclk_o,
  output logic              sdata_o,
  input  logic              init_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              done_ok_o,
  output logic              error_o,
  output logic [1:0]        err_code_o
);
  cfg_state_e        state_q, state_d;
  logic [HALF_W-1:0] half_q;
  logic [CNT_W-1:0]  left_q;
  logic              err_q, ok_q;
  cfg_err_e          code_q, code_d;

  logic crc_bad, tick, tmo_exp, tmo_clr, tmo_run, tick_restart;
  logic load, shift, dec, set_err, set_ok, accept;
  logic msb, last_bit;

  assign crc_bad = init_i && !done_i;
  assign accept  = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    load    = 1'b0;
    shift   = 1'b0;
    dec     = 1'b0;
    set_err = 1'b0;
    set_ok  = 1'b0;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_PROG_ON;
      ST_PROG_ON: begin
        if (init_i) state_d = ST_PROG_OFF;
        else if (tmo_exp) begin
          set_err = 1'b1; code_d = ERR_INIT_START; state_d = ST_IDLE;
        end
      end
      ST_PROG_OFF: begin
        if (!init_i) state_d = (left_q == '0) ? ST_FIN_LO : ST_FETCH;
        else if (tmo_exp) begin
          set_err = 1'b1; code_d = ERR_INIT_CLEAR; state_d = ST_IDLE;
        end
      end
      ST_FETCH: begin
        if (crc_bad) begin
          set_err = 1'b1; code_d = ERR_CRC; state_d = ST_IDLE;
        end else if (data_valid_i) begin
          load = 1'b1; state_d = ST_BIT_LO;
        end
      end
      ST_BIT_LO:   if (tick) state_d = ST_BIT_HI;
      ST_BIT_HI: begin
        if (tick) begin
          shift = 1'b1;
          if (last_bit) begin
            dec     = 1'b1;
            state_d = (left_q == CNT_W'(1)) ? ST_FIN_LO : ST_FETCH;
          end else begin
            state_d = ST_BIT_LO;
          end
        end
      end
      ST_FIN_LO: begin
        if (tmo_exp) begin
          set_err = 1'b1; code_d = ERR_DONE_TMO; state_d = ST_IDLE;
        end else if (tick) begin
          if (done_i) begin
            set_ok = 1'b1; state_d = ST_IDLE;
          end else begin
            state_d = ST_FIN_HI;
          end
        end
      end
      ST_FIN_HI: begin
        if (tmo_exp) begin
          set_err = 1'b1; code_d = ERR_DONE_TMO; state_d = ST_IDLE;
        end else if (tick) begin
          state_d = ST_FIN_LO;
        end
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      left_q  <= '0;
      err_q   <= 1'b0;
      ok_q    <= 1'b0;
      code_q  <= ERR_INIT_START;
    end else begin
      state_q <= state_d;
      if (accept) begin
        half_q <= half_per_i;
        left_q <= byte_cnt_i;
        err_q  <= 1'b0;
        ok_q   <= 1'b0;
      end
      if (dec)     left_q <= left_q - CNT_W'(1);
      if (set_err) begin
        err_q  <= 1'b1;
        code_q <= code_d;
      end
      if (set_ok)  ok_q <= 1'b1;
    end
  end

  // one timeout window per wait phase, restarted on entering a new phase
  assign tmo_run      = (wait_grp(state_q) != 2'd0);
  assign tmo_clr      = (wait_grp(state_d) != wait_grp(state_q));
  assign tick_restart = (state_d != state_q) || (state_q == ST_IDLE);

  cfg_timeout #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmo_clr),
    .run_i    (tmo_run),
    .expired_o(tmo_exp)
  );

  cfg_half_timer #(.W(HALF_W)) u_half (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(tick_restart),
    .half_i   (half_q),
    .last_o   (tick)
  );

  cfg_byte_shifter #(.DATA_W(8)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (data_i),
    .shift_i   (shift),
    .msb_o     (msb),
    .last_bit_o(last_bit)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign prog_o       = (state_q == ST_PROG_ON);
  assign cclk_o       = (state_q == ST_BIT_HI) || (state_q == ST_FIN_HI);
  assign sdata_o      = (state_q == ST_FIN_LO) || (state_q == ST_FIN_HI) ||
                        (((state_q == ST_BIT_LO) || (state_q == ST_BIT_HI)) && msb);
  assign data_ready_o = (state_q == ST_FETCH) && !crc_bad;
  assign done_ok_o    = ok_q;
  assign error_o      = err_q;
  assign err_code_o   = code_q;

  assert_sdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_o && $past(cclk_o)) |-> $stable(sdata_o));

  assert_crc_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && init_i && !done_i) |=>
      (error_o && err_code_o == ERR_CRC && !cclk_o));

  assert_ok_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_ok_o) |-> $past(done_i));

  assert_err_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> (!busy_o && !prog_o && !cclk_o));

endmodule

// File: tb/cfg_serial_master_bench.sv
`timescale 1ns/1ps
module cfg_serial_master_bench;
  localparam int TMO = 300;

  // {n_bytes, half_period, done_extra_pulses, pattern}
  localparam logic [31:0] VEC [4] = '{
    {8'd1, 8'd1, 8'd2, 8'hA5},
    {8'd3, 8'd2, 8'd0, 8'h3C},
    {8'd4, 8'd3, 8'd5, 8'h81},
    {8'd2, 8'd0, 8'd1, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cnt_in = '0;
  logic [3:0] half_in = '0;
  logic [7:0] din = '0;
  logic dvalid = 1'b0, init_r = 1'b0, done_r = 1'b0;
  logic dready, prog, cclk, sdata, busy, dok, err;
  logic [1:0] ecode;

  int checks = 0, fails = 0;
  int src_n = 0, src_idx = 0, n_exp = 0, exp_hi = 1;
  bit fire_q = 0;
  logic [7:0] src_mem [16];
  logic [7:0] rx_byte [16];
  int rx_edges = 0, dp_edges = 0, dp_bad = 0, hi_cnt = 0, hi_bad = 0, stab_bad = 0, prog_rises = 0;
  logic prev_cclk = 0, prev_sdata = 0, prev_prog = 0;
  int rise_dly = 0, clr_dly = 0, crc_after = -1, done_thr = -1, pcnt = 0, ccnt = 0;
  bit cleared = 0;

  always #2.5 clk = ~clk;

  cfg_serial_master #(.CNT_W(8), .HALF_W(4), .TMO_CYCLES(TMO)) u_cfg_serial_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_cnt_i(cnt_in),
    .half_per_i(half_in), .data_i(din), .data_valid_i(dvalid),
    .data_ready_o(dready), .prog_o(prog), .cclk_o(cclk), .sdata_o(sdata),
    .init_i(init_r), .done_i(done_r), .busy_o(busy), .done_ok_o(dok),
    .error_o(err), .err_code_o(ecode)
  );

  // monitor, device model and byte source, all away from the rising edge
  always @(negedge clk) begin
    if (cclk && !prev_cclk) begin
      if (rx_edges < 8 * n_exp)
        rx_byte[rx_edges / 8] = {rx_byte[rx_edges / 8][6:0], sdata};
      else begin
        dp_edges++;
        if (!sdata) dp_bad++;
      end
      rx_edges++;
    end
    if (cclk) begin
      if (prev_cclk && sdata != prev_sdata) stab_bad++;
      hi_cnt++;
    end else begin
      if (prev_cclk && hi_cnt != exp_hi) hi_bad++;
      hi_cnt = 0;
    end
    if (prog && !prev_prog) prog_rises++;
    prev_cclk = cclk; prev_sdata = sdata; prev_prog = prog;

    if (fire_q) begin src_idx++; fire_q = 0; end

    if (prog) begin
      cleared = 0; rx_edges = 0; done_r = 0; ccnt = 0;
      if (rise_dly >= 0 && pcnt >= rise_dly) init_r = 1;
      pcnt++;
    end else begin
      pcnt = 0;
      if (init_r && !cleared && clr_dly >= 0) begin
        if (ccnt >= clr_dly) begin init_r = 0; cleared = 1; end
        ccnt++;
      end
    end
    if (cleared && crc_after >= 0 && src_idx >= crc_after) init_r = 1;
    if (cleared && done_thr >= 0 && rx_edges >= done_thr) done_r = 1;

    dvalid = (src_idx < src_n);
    din    = (src_idx < src_n && src_idx < 16) ? src_mem[src_idx] : 8'h00;
    #1;
    fire_q = dready && dvalid;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_job(int n, int h, int thr, int rdly, int cdly, int crc, int mid);
    @(posedge clk); #1;
    src_n = n; n_exp = n; cnt_in = 8'(n); half_in = 4'(h); exp_hi = (h == 0) ? 1 : h;
    rise_dly = rdly; clr_dly = cdly; crc_after = crc; done_thr = thr;
    src_idx = 0; fire_q = 0; rx_edges = 0; dp_edges = 0; dp_bad = 0; hi_bad = 0;
    stab_bad = 0; prog_rises = 0; hi_cnt = 0; init_r = 0; done_r = 0; cleared = 0;
    pcnt = 0; ccnt = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    #1;
    chk(prog && busy && !err && !dok, "R1", "start raises prog/busy, clears status",
        {prog, busy, err, dok}, 4'b1100);
    if (mid > 0) begin
      repeat (mid) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    for (int g = 0; g < 5000 && busy; g++) @(negedge clk);
    #1;
  endtask

  task automatic check_error(string req, int code);
    chk(err && ecode == 2'(code), req, "error code", {err, ecode}, 4 + code);
    chk(!busy && !prog && !cclk && !dok, "R10", "released after error",
        {busy, prog, cclk, dok}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({busy, prog, cclk, sdata, dready, dok, err} == 7'b0, "R11", "reset outputs",
        {busy, prog, cclk, sdata, dready, dok, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (VEC[v]) begin
      int n = int'(VEC[v][31:24]);
      int h = int'(VEC[v][23:16]);
      int ex = int'(VEC[v][15:8]);
      logic [7:0] pat = VEC[v][7:0];
      for (int j = 0; j < n; j++) src_mem[j] = 8'(pat + 8'(j * 8'h47));
      run_job(n, h, 8 * n + ex, 2, 4, -1, 0);
      for (int j = 0; j < n; j++)
        chk(rx_byte[j] == src_mem[j], "R4", "byte msb-first", rx_byte[j], src_mem[j]);
      chk(rx_edges - dp_edges == 8 * n, "R4", "data edges", rx_edges - dp_edges, 8 * n);
      chk(stab_bad == 0, "R4", "sdata stable in high phase", stab_bad, 0);
      chk(hi_bad == 0, "R5", "high phase length", hi_bad, 0);
      chk(dp_bad == 0 && dp_edges == ex, "R7", "done-phase pulses with sdata high",
          dp_edges, ex);
      chk(dok && !err && !busy, "R7", "done_ok at end", {dok, err, busy}, 4);
      chk(src_idx == n, "R6", "bytes taken", src_idx, n);
    end

    // R1: start while busy is ignored
    for (int j = 0; j < 3; j++) src_mem[j] = 8'(8'h5A ^ j);
    run_job(3, 2, 24, 2, 3, -1, 30);
    chk(prog_rises == 1, "R1", "prog raised once", prog_rises, 1);
    chk(dok && rx_byte[2] == src_mem[2], "R1", "load completes", rx_byte[2], src_mem[2]);

    // R2: init never asserts
    run_job(1, 1, 8, -1, 2, -1, 0);
    check_error("R2", 0);
    chk(rx_edges == 0, "R2", "no clock edges", rx_edges, 0);

    // R3: init never clears
    run_job(1, 1, 8, 1, -1, -1, 0);
    check_error("R3", 1);

    // R6: checksum error flagged after first byte
    for (int j = 0; j < 3; j++) src_mem[j] = 8'(8'hC3 + j);
    run_job(3, 1, -1, 2, 3, 1, 0);
    check_error("R6", 2);
    chk(rx_edges == 8 && src_idx == 1, "R6", "stops before second byte", rx_edges, 8);

    // R8: done never arrives
    src_mem[0] = 8'h96;
    run_job(1, 1, -1, 1, 2, -1, 0);
    check_error("R8", 3);
    chk(src_idx == 1 && rx_byte[0] == 8'h96, "R8", "byte sent before done wait", rx_byte[0], 8'h96);

    // R9: zero bytes goes straight to done phase
    run_job(0, 2, 3, 1, 2, -1, 0);
    chk(src_idx == 0, "R9", "no bytes taken", src_idx, 0);
    chk(dok && dp_edges == 3 && dp_bad == 0, "R9", "done-phase pulses", dp_edges, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule